// File: doc/BRIEF.md
# Downstream Frame Assembler and Serializer

This block turns the codeword streams of one downstream channel into a continuous serial bitstream for the physical medium interface. Each frame holds a pair of fixed sync bytes, then one header codeword, then a run of interleaved payload codewords. With default parameters that is 2 + 16 + 12 x 66 = 810 bytes. Frames follow one another with no idle gap, and the block keeps sending even when its sources fall behind.

Header and payload bytes arrive on two byte-wide ready/valid ports. The block holds a one-byte staging slot and fills it while the previous byte is still being shifted out. Header bytes are therefore requested during the second sync byte, and payload bytes during the last header byte. A bit-enable input sets the line rate. Each enabled clock consumes one bit, most significant bit first. The output carries a valid qualifier, a strobe on the first bit of each byte, and a strobe on the first bit of each frame.

If a source has no byte ready when its slot is due on the line, the block sends 0x00 in that slot and sets a sticky underrun flag. The frame timing is not disturbed.

Top module: `dsf_framer`

## Requirements
- R1: A frame is the byte SYNC0 (default 0xF6), then SYNC1 (default 0x28), then HDR_LEN header bytes, then NUM_BLK*BLK_LEN payload bytes, taken from the ports in acceptance order. The defaults give 810 bytes.
- R2: The first bit of the next frame's SYNC0 directly follows the last payload bit. There is no gap, and every frame has exactly FRAME_BYTES bytes.
- R3: Once the first byte is loaded, ser_valid_o equals bit_en_i. Each byte goes out MSB first, one bit per cycle with bit_en_i high. While bit_en_i is low, ser_data_o holds its value.
- R4: sym_strobe_o is high exactly on the valid bit that is bit 7 of a byte, which is every eighth valid bit.
- R5: frame_start_o is high exactly on the first valid bit of SYNC0, and at no other time.
- R6: hdr_ready_o is raised only for header slots and pld_ready_o only for payload slots. The two are never high together, and each accepted byte fills exactly one slot.
- R7: A header or payload slot that reaches the line with no byte accepted is sent as 0x00, and the frame timing is unchanged.
- R8: underrun_o rises on the first bit of the first substituted byte, then stays high until reset, and reset clears it.
- R9: During reset every output is low. After reset is released, the first frame begins one cycle later with SYNC0.
- R10: The first header byte of a frame is accepted while SYNC1 is on the line. The first payload byte is accepted while the last header byte is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Consume one output bit this cycle |
| hdr_data_i | input | 8 | Header codeword byte |
| hdr_valid_i | input | 1 | Header byte offered |
| hdr_ready_o | output | 1 | Header byte taken when valid |
| pld_data_i | input | 8 | Interleaved payload codeword byte |
| pld_valid_i | input | 1 | Payload byte offered |
| pld_ready_o | output | 1 | Payload byte taken when valid |
| ser_data_o | output | 1 | Serial data, MSB first |
| ser_valid_o | output | 1 | Bit on ser_data_o consumed this cycle |
| sym_strobe_o | output | 1 | First bit of a byte |
| frame_start_o | output | 1 | First bit of a frame |
| underrun_o | output | 1 | Sticky source underrun |

## Verification
The bench uses a 13-byte frame and runs fourteen frames. It predicts every bit, and it looks hardest at the points where one section gives way to the next. A wrong section boundary would put sync or header bytes at the wrong offset, or would pull a payload byte into a header slot. A prefetch that is late would show as a first header accept after SYNC1 or a first payload accept after the last header byte. A bypass that is broken would drop or duplicate a byte under source gaps or gapped bit enables. A whole frame with no header, and a later frame with no payload, check that zeros go out with unchanged strobes, that the flag rises on the exact first substituted bit, and that the flag survives until a second reset.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  typedef enum logic [1:0] {
    SEC_SYNC = 2'd0,
    SEC_HDR  = 2'd1,
    SEC_PLD  = 2'd2
  } sec_e;
endpackage

// File: rtl/dsf_position.sv
// Byte position of the staging slot within the frame.
module dsf_position
  import dsf_pkg::*;
#(
  parameter int FRAME_BYTES = 810,
  parameter int HDR_LEN     = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output sec_e sec_o,
  output logic first_o,
  output logic sync_sel_o
);
  localparam int POS_W = $clog2(FRAME_BYTES);
  localparam logic [POS_W-1:0] LAST    = POS_W'(FRAME_BYTES - 1);
  localparam logic [POS_W-1:0] HDR_BEG = POS_W'(2);
  localparam logic [POS_W-1:0] PLD_BEG = POS_W'(2 + HDR_LEN);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (adv_i) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  always_comb begin
    if (pos_q < HDR_BEG)      sec_o = SEC_SYNC;
    else if (pos_q < PLD_BEG) sec_o = SEC_HDR;
    else                      sec_o = SEC_PLD;
  end

  assign first_o    = (pos_q == '0);
  assign sync_sel_o = pos_q[0];
endmodule

// File: rtl/dsf_stager.sv
// One-byte staging slot with bypass; selects sync constants or source data.
module dsf_stager
  import dsf_pkg::*;
#(
  parameter logic [7:0] SYNC0 = 8'hF6,
  parameter logic [7:0] SYNC1 = 8'h28
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  sec_e       sec_i,
  input  logic       sync_sel_i,
  input  logic       take_i,
  input  logic [7:0] hdr_data_i,
  input  logic       hdr_valid_i,
  output logic       hdr_ready_o,
  input  logic [7:0] pld_data_i,
  input  logic       pld_valid_i,
  output logic       pld_ready_o,
  output logic [7:0] byte_o,
  output logic       miss_o
);
  logic [7:0] slot_q;
  logic       full_q;
  logic       want, acc;
  logic [7:0] in_byte;

  assign want        = (sec_i != SEC_SYNC) && !full_q;
  assign hdr_ready_o = want && (sec_i == SEC_HDR);
  assign pld_ready_o = want && (sec_i == SEC_PLD);
  assign acc         = (hdr_ready_o && hdr_valid_i) || (pld_ready_o && pld_valid_i);
  assign in_byte     = (sec_i == SEC_HDR) ? hdr_data_i : pld_data_i;

  always_comb begin
    if (sec_i == SEC_SYNC) byte_o = sync_sel_i ? SYNC1 : SYNC0;
    else if (full_q)       byte_o = slot_q;
    else if (acc)          byte_o = in_byte;
    else                   byte_o = 8'h00;
  end

  assign miss_o = take_i && (sec_i != SEC_SYNC) && !full_q && !acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      full_q <= 1'b0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (acc) begin
      slot_q <= in_byte;
      full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dsf_serializer.sv
// MSB-first shifter with byte and frame strobes.
module dsf_serializer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic [7:0] byte_i,
  input  logic       first_i,
  output logic       take_o,
  output logic       running_o,
  output logic       ser_data_o,
  output logic       ser_valid_o,
  output logic       sym_strobe_o,
  output logic       frame_start_o
);
  logic [7:0] sh_q;
  logic [2:0] bcnt_q;
  logic       first_q, loaded_q;

  assign take_o = !loaded_q || (bit_en_i && (bcnt_q == 3'd7));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      bcnt_q   <= '0;
      first_q  <= 1'b0;
      loaded_q <= 1'b0;
    end else if (take_o) begin
      sh_q     <= byte_i;
      bcnt_q   <= '0;
      first_q  <= first_i;
      loaded_q <= 1'b1;
    end else if (bit_en_i) begin
      sh_q   <= {sh_q[6:0], 1'b0};
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assign running_o     = loaded_q;
  assign ser_data_o    = sh_q[7];
  assign ser_valid_o   = loaded_q && bit_en_i;
  assign sym_strobe_o  = ser_valid_o && (bcnt_q == 3'd0);
  assign frame_start_o = sym_strobe_o && first_q;
endmodule

// File: rtl/dsf_framer.sv
module dsf_framer
  import dsf_pkg::*;
#(
  parameter int         HDR_LEN = 16,
  parameter int         BLK_LEN = 66,
  parameter int         NUM_BLK = 12,
  parameter logic [7:0] SYNC0   = 8'hF6,
  parameter logic [7:0] SYNC1   = 8'h28
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic [7:0] hdr_data_i,
  input  logic       hdr_valid_i,
  output logic       hdr_ready_o,
  input  logic [7:0] pld_data_i,
  input  logic       pld_valid_i,
  output logic       pld_ready_o,
  output logic       ser_data_o,
  output logic       ser_valid_o,
  output logic       sym_strobe_o,
  output logic       frame_start_o,
  output logic       underrun_o
);
  localparam int FRAME_BYTES = 2 + HDR_LEN + BLK_LEN * NUM_BLK;

  sec_e       sec;
  logic       first, sync_sel, take, miss, running;
  logic [7:0] stage_byte;
  logic       underrun_q;

  dsf_position #(.FRAME_BYTES(FRAME_BYTES), .HDR_LEN(HDR_LEN)) u_pos (
    .clk_i, .rst_ni, .adv_i(take), .sec_o(sec), .first_o(first), .sync_sel_o(sync_sel)
  );

  dsf_stager #(.SYNC0(SYNC0), .SYNC1(SYNC1)) u_stg (
    .clk_i, .rst_ni, .sec_i(sec), .sync_sel_i(sync_sel), .take_i(take),
    .hdr_data_i, .hdr_valid_i, .hdr_ready_o,
    .pld_data_i, .pld_valid_i, .pld_ready_o,
    .byte_o(stage_byte), .miss_o(miss)
  );

  dsf_serializer u_ser (
    .clk_i, .rst_ni, .bit_en_i, .byte_i(stage_byte), .first_i(first),
    .take_o(take), .running_o(running), .ser_data_o, .ser_valid_o,
    .sym_strobe_o, .frame_start_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   underrun_q <= 1'b0;
    else if (miss) underrun_q <= 1'b1;
  end
  assign underrun_o = underrun_q;
endmodule

// File: rtl/dsf_framer_chk.sv
module dsf_framer_chk #(
  parameter int FRAME_BYTES = 810
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic running,
  input logic hdr_ready_o,
  input logic pld_ready_o,
  input logic ser_data_o,
  input logic ser_valid_o,
  input logic sym_strobe_o,
  input logic frame_start_o,
  input logic underrun_o
);
  localparam int CW = $clog2(FRAME_BYTES + 1);
  logic [CW-1:0] sym_cnt_q;
  logic [3:0]    bit_cnt_q;
  logic          seen_fs_q, seen_sym_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_cnt_q  <= '0;
      bit_cnt_q  <= '0;
      seen_fs_q  <= 1'b0;
      seen_sym_q <= 1'b0;
    end else begin
      if (frame_start_o) begin
        sym_cnt_q <= CW'(1);
        seen_fs_q <= 1'b1;
      end else if (sym_strobe_o) begin
        sym_cnt_q <= sym_cnt_q + 1'b1;
      end
      if (sym_strobe_o) begin
        bit_cnt_q  <= 4'd1;
        seen_sym_q <= 1'b1;
      end else if (ser_valid_o) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  // R3
  valid_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> bit_en_i);
  // R3
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !bit_en_i) |=> $stable(ser_data_o));
  // R4
  byte_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_strobe_o && seen_sym_q) |-> (bit_cnt_q == 4'd8));
  // R5
  fs_on_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> sym_strobe_o);
  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && seen_fs_q) |-> (sym_cnt_q == CW'(FRAME_BYTES)));
  // R6
  one_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_ready_o && pld_ready_o));
  // R8
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);
endmodule

bind dsf_framer dsf_framer_chk #(.FRAME_BYTES(FRAME_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .running(running),
  .hdr_ready_o(hdr_ready_o), .pld_ready_o(pld_ready_o), .ser_data_o(ser_data_o),
  .ser_valid_o(ser_valid_o), .sym_strobe_o(sym_strobe_o),
  .frame_start_o(frame_start_o), .underrun_o(underrun_o)
);

// File: tb/dsf_framer_test.sv
`timescale 1ns/1ps
module dsf_framer_test;
  localparam int H  = 3;
  localparam int B  = 4;
  localparam int N  = 2;
  localparam int FB = 2 + H + B * N;
  localparam logic [7:0] S0 = 8'hF6;
  localparam logic [7:0] S1 = 8'h28;

  logic clk_i = 1'b0, rst_ni = 1'b0, bit_en_i = 1'b0;
  logic [7:0] hdr_data_i = '0, pld_data_i = '0;
  logic hdr_valid_i = 1'b0, pld_valid_i = 1'b0;
  logic hdr_ready_o, pld_ready_o, ser_data_o, ser_valid_o;
  logic sym_strobe_o, frame_start_o, underrun_o;

  always #4 clk_i = ~clk_i;

  dsf_framer #(.HDR_LEN(H), .BLK_LEN(B), .NUM_BLK(N), .SYNC0(S0), .SYNC1(S1)) uut (
    .clk_i, .rst_ni, .bit_en_i, .hdr_data_i, .hdr_valid_i, .hdr_ready_o,
    .pld_data_i, .pld_valid_i, .pld_ready_o, .ser_data_o, .ser_valid_o,
    .sym_strobe_o, .frame_start_o, .underrun_o
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] hval(input int k);
    return 8'((k * 7 + 1) & 255);
  endfunction
  function automatic logic [7:0] pval(input int k);
    return 8'((k * 13 + 5) & 255);
  endfunction

  initial begin
    int cyc = 0, bi = 0, bytep = 0, fr = 0;
    int hk = 0, pk = 0, hs = 0, ps = 0, hf = 0, pf = 0;
    bit started = 0, ur_exp = 0, acc_h = 0, acc_p = 0, gap;
    bit hdr_gate = 1, pld_gate = 1;
    logic [7:0] exp_byte = '0;

    repeat (3) @(negedge clk_i);
    #1;
    // R9 reset state
    chk(ser_valid_o == 0 && sym_strobe_o == 0 && frame_start_o == 0, "R9 outputs in reset", ser_valid_o, 0);
    chk(hdr_ready_o == 0 && pld_ready_o == 0 && underrun_o == 0, "R9 ready/underrun in reset", hdr_ready_o, 0);

    forever begin
      @(negedge clk_i);
      cyc++;
      if (cyc == 1) rst_ni = 1'b1;
      if (acc_h) hs++;
      if (acc_p) ps++;
      gap = (fr >= 4 && fr < 8);
      bit_en_i    = gap ? (cyc % 3 != 0) : 1'b1;
      hdr_valid_i = hdr_gate && !(gap && cyc % 4 == 1);
      pld_valid_i = pld_gate && !(gap && cyc % 2 == 0);
      hdr_data_i  = hval(hs);
      pld_data_i  = pval(ps);
      #1;
      acc_h = hdr_ready_o && hdr_valid_i;
      acc_p = pld_ready_o && pld_valid_i;

      if (cyc == 1) chk(ser_valid_o == 0, "R9 no bit before first load", ser_valid_o, 0);
      if (cyc == 2) chk(ser_valid_o && frame_start_o, "R9 frame starts one cycle after reset", frame_start_o, 1);
      // R6
      chk(!(hdr_ready_o && pld_ready_o), "R6 ready exclusive", {hdr_ready_o, pld_ready_o}, 0);
      if (started) chk(ser_valid_o == bit_en_i, "R3 valid follows enable", ser_valid_o, bit_en_i);

      if (ser_valid_o) begin
        started = 1;
        if (bi == 0) begin
          if (bytep == 0) begin
            hf = 0; pf = 0;
            hdr_gate = (fr != 9);
            pld_gate = (fr != 11);
            exp_byte = S0;
          end else if (bytep == 1) exp_byte = S1;
          else if (bytep < 2 + H) begin
            if (fr == 9) begin exp_byte = 8'h00; ur_exp = 1; end
            else begin exp_byte = hval(hk); hk++; end
          end else begin
            if (fr == 11) begin exp_byte = 8'h00; ur_exp = 1; end
            else begin exp_byte = pval(pk); pk++; end
          end
        end
        // R1 R2 R7 byte content and order
        chk(ser_data_o == exp_byte[7-bi], "R1 serial bit", ser_data_o, exp_byte[7-bi]);
        chk(sym_strobe_o == (bi == 0), "R4 symbol strobe", sym_strobe_o, bi == 0);
        chk(frame_start_o == (bi == 0 && bytep == 0), "R5 frame start", frame_start_o, bi == 0 && bytep == 0);
      end

      if (fr < 4 && started) begin
        if (acc_h && hf == 0) chk(bytep == 1, "R10 header prefetch during SYNC1", bytep, 1);
        if (acc_p && pf == 0) chk(bytep == 1 + H, "R10 payload prefetch during last header byte", bytep, 1 + H);
      end
      if (acc_h) hf++;
      if (acc_p) pf++;
      chk(underrun_o == ur_exp, "R8 underrun flag", underrun_o, ur_exp);

      if (ser_valid_o) begin
        bi++;
        if (bi == 8) begin
          bi = 0; bytep++;
          if (bytep == FB) begin bytep = 0; fr++; end
        end
      end
      if (fr == 14) break;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        break;
      end
    end

    if (acc_h) hs++;
    if (acc_p) ps++;
    // R6 every accepted byte used in exactly one slot
    chk(hs == hk, "R6 header bytes consumed", hs, hk);
    chk(ps == pk, "R6 payload bytes consumed", ps, pk);
    chk(ur_exp == 1, "R7 underrun exercised", ur_exp, 1);

    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(underrun_o == 0, "R8 reset clears underrun", underrun_o, 0);
    chk(ser_valid_o == 0 && hdr_ready_o == 0 && pld_ready_o == 0, "R9 outputs low in second reset", ser_valid_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule